// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a 32-bit register bus and a byte-oriented serial engine. Software sees five word-spaced registers. They hold the last received byte, a baud divisor, event status, interrupt control and a debug word. A store to the data register hands its low byte to the transmitter and marks a transmit event. A byte accepted from the receiver is kept for software and marks a receive event.

Both events stay set until software acknowledges them by writing ones to the status register. They drive a single level interrupt, gated by one enable per event. While a received byte is still unacknowledged, the block holds off the receiver through a ready signal. A byte offered anyway is dropped.

The bus transfer lasts one cycle: `bus_valid` with `bus_we` high is a store, and with `bus_we` low it is a load. Load data appears on `bus_rdata` one cycle later and holds until the next load. The register index is the byte address shifted right by two.

Top module: `uart_csr_front`

## Requirements
- R1: After reset, the register contents read back as follows: index 0, 1, 3 and 4 read 0, and status (index 2) reads 0x1. `irq` is 0 and `rx_ready` is 1.
- R2: A store to index 0 raises `tx_strobe` for exactly the next cycle, with `tx_byte` equal to the low 8 bits of the stored word. It also sets status bit 2 (transmit event). No other access raises `tx_strobe`.
- R3: A store to index 2 clears status bit 1 and status bit 2 wherever the stored word has a 1 in that position. Every other stored bit is ignored. Status bit 0 (transmit-empty) always reads 1.
- R4: A `rx_strobe` while `rx_ready` is 1 stores `rx_byte` as the value read at index 0 (in bits 7:0, upper bits 0). It sets status bit 1 (receive event), and `rx_ready` drops to 0 in the next cycle.
- R5: While status bit 1 is set, `rx_ready` is 0, and a `rx_strobe` is ignored: the byte read at index 0 does not change.
- R6: `irq` is 1 exactly when (control bit 0 and status bit 1) or (control bit 1 and status bit 2). Otherwise it is 0. It follows the stored values with no added delay.
- R7: Index 1 keeps the low DIV_W (default 16) bits of a stored word. Index 3 keeps bits 2:0, where bit 2 is a pass-through enable with no effect on behaviour. Index 4 keeps bit 0. Unkept bits read 0.
- R8: Indices 5 to 7 read as 0, and stores to them change no register.
- R9: When an accepted `rx_strobe` and a store of status bit 1 as 1 happen in the same cycle, the byte is stored and the receive event ends up set.
- R10: Load data is presented on `bus_rdata` in the cycle after the load. It keeps that value through later cycles that carry no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus transfer this cycle |
| bus_we | input | 1 | 1 for store, 0 for load |
| bus_addr | input | ADDR_W | Byte address; bits ADDR_W-1:2 select the register |
| bus_wdata | input | DATA_W | Store data |
| bus_rdata | output | DATA_W | Load data, one cycle after the load |
| tx_strobe | output | 1 | One-cycle pulse carrying a byte to the transmitter |
| tx_byte | output | BYTE_W | Byte to transmit, valid with `tx_strobe` |
| rx_strobe | input | 1 | Receiver offers a byte |
| rx_byte | input | BYTE_W | Byte offered by the receiver |
| rx_ready | output | 1 | Block can accept a received byte |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume a well-behaved environment on three points:
- `bus_valid`, `bus_we`, `bus_addr` and `bus_wdata` are known, and unchanged across each clock edge.
- `rx_strobe` lasts a single cycle per byte.
- The receiver may still strobe while `rx_ready` is low. The dropping rule is checked against exactly that case.

The stimulus drives every input at the falling edge and holds it for one full cycle, so each transfer and each strobe spans exactly one rising edge. The stimulus also offers a byte on purpose while the receive event is pending, and it lines a receive strobe up with a status acknowledge in the same cycle. This way the refusal path and the priority path are both exercised, not just assumed.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

    // register indices (byte address >> 2)
    localparam int IDX_DATA = 0;
    localparam int IDX_DIV  = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_CTRL = 3;
    localparam int IDX_DBG  = 4;
    localparam int NUM_REGS = 5;

    // status bit positions
    localparam int ST_TXEMPTY = 0;
    localparam int ST_RXEVT   = 1;
    localparam int ST_TXEVT   = 2;

    // control bit positions
    localparam int CT_RXIE   = 0;
    localparam int CT_TXIE   = 1;
    localparam int CT_PASS   = 2;
    localparam int CTRL_BITS = 3;

    typedef struct packed {
        logic rx_evt;
        logic tx_evt;
    } evt_flags_t;

endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode #(
    parameter int ADDR_W   = 5,
    parameter int NUM_SEL  = 5
) (
    input  logic               valid,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_SEL-1:0] wr_sel,
    output logic [NUM_SEL-1:0] rd_sel,
    output logic               rd_any
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    assign idx    = addr[ADDR_W-1:2];
    assign rd_any = valid && !we;

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign wr_sel[g] = valid &&  we && (idx == IDX_W'(g));
        assign rd_sel[g] = valid && !we && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/uart_csr_events.sv
module uart_csr_events
    import uart_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_rx,
    input  logic       set_tx,
    input  logic       clr_rx,
    input  logic       clr_tx,
    output evt_flags_t flags
);
    evt_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr_rx) flags_d.rx_evt = 1'b0;
        if (clr_tx) flags_d.tx_evt = 1'b0;
        // a new event outranks an acknowledge in the same cycle
        if (set_rx) flags_d.rx_evt = 1'b1;
        if (set_tx) flags_d.tx_evt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/uart_csr_front.sv
module uart_csr_front
    import uart_csr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_strobe,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              irq
);
    localparam int NSEL = 1 << (ADDR_W - 2);

    typedef struct packed {
        logic [BYTE_W-1:0]    rxdata;
        logic [DIV_W-1:0]     div;
        logic [CTRL_BITS-1:0] ctrl;
        logic                 dbg;
        logic [DATA_W-1:0]    rdata;
        logic                 tx_stb;
        logic [BYTE_W-1:0]    txb;
    } regs_t;

    regs_t            st_d, st_q;
    logic [NSEL-1:0]  wr_sel, rd_sel;
    logic             rd_any;
    evt_flags_t       flags;
    logic             rx_take;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] rd_val;

    uart_csr_decode #(.ADDR_W(ADDR_W), .NUM_SEL(NSEL)) u_dec (
        .valid  (bus_valid),
        .we     (bus_we),
        .addr   (bus_addr),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel),
        .rd_any (rd_any)
    );

    assign rx_take = rx_strobe && !flags.rx_evt;

    uart_csr_events u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_rx (rx_take),
        .set_tx (wr_sel[IDX_DATA]),
        .clr_rx (wr_sel[IDX_STAT] && bus_wdata[ST_RXEVT]),
        .clr_tx (wr_sel[IDX_STAT] && bus_wdata[ST_TXEVT]),
        .flags  (flags)
    );

    always_comb begin
        stat_word             = '0;
        stat_word[ST_TXEMPTY] = 1'b1;
        stat_word[ST_RXEVT]   = flags.rx_evt;
        stat_word[ST_TXEVT]   = flags.tx_evt;

        rd_val = '0;
        if (rd_sel[IDX_DATA]) rd_val = DATA_W'(st_q.rxdata);
        if (rd_sel[IDX_DIV])  rd_val = DATA_W'(st_q.div);
        if (rd_sel[IDX_STAT]) rd_val = stat_word;
        if (rd_sel[IDX_CTRL]) rd_val = DATA_W'(st_q.ctrl);
        if (rd_sel[IDX_DBG])  rd_val = DATA_W'(st_q.dbg);
    end

    always_comb begin
        st_d        = st_q;
        st_d.tx_stb = wr_sel[IDX_DATA];
        if (wr_sel[IDX_DATA]) st_d.txb    = bus_wdata[BYTE_W-1:0];
        if (wr_sel[IDX_DIV])  st_d.div    = bus_wdata[DIV_W-1:0];
        if (wr_sel[IDX_CTRL]) st_d.ctrl   = bus_wdata[CTRL_BITS-1:0];
        if (wr_sel[IDX_DBG])  st_d.dbg    = bus_wdata[0];
        if (rx_take)          st_d.rxdata = rx_byte;
        if (rd_any)           st_d.rdata  = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign tx_strobe = st_q.tx_stb;
    assign tx_byte   = st_q.txb;
    assign rx_ready  = !flags.rx_evt;
    assign irq       = (st_q.ctrl[CT_RXIE] && flags.rx_evt) ||
                       (st_q.ctrl[CT_TXIE] && flags.tx_evt);

    // plain views of stored state for the bound checker
    logic [BYTE_W-1:0]    chk_rxdata;
    logic [CTRL_BITS-1:0] chk_ctrl;
    assign chk_rxdata = st_q.rxdata;
    assign chk_ctrl   = st_q.ctrl;
endmodule

// File: rtl/uart_csr_front_chk.sv
module uart_csr_front_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_strobe,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              rx_strobe,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              rx_ready,
    input logic              irq,
    input logic [BYTE_W-1:0] rxdata,
    input logic [2:0]        ctrl
);
    localparam int IDX_W = ADDR_W - 2;
    logic [IDX_W-1:0] idx;
    logic wr_data, rd_stat, rd_oob, ack_rx;
    assign idx     = bus_addr[ADDR_W-1:2];
    assign wr_data = bus_valid && bus_we && (idx == IDX_W'(0));
    assign rd_stat = bus_valid && !bus_we && (idx == IDX_W'(2));
    assign rd_oob  = bus_valid && !bus_we && (int'(idx) >= 5);
    assign ack_rx  = bus_valid && bus_we && (idx == IDX_W'(2)) && bus_wdata[1];

    assert_tx_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> tx_strobe && tx_byte == $past(bus_wdata[BYTE_W-1:0]));
    assert_tx_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> !tx_strobe);
    assert_txempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> bus_rdata[0]);
    assert_rx_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe && rx_ready |=> !rx_ready && rxdata == $past(rx_byte));
    assert_rx_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe && !rx_ready |=> rxdata == $past(rxdata));
    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[1:0] == 2'b00 |-> !irq);
    assert_irq_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready && ctrl[0] |-> irq);
    assert_oob_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oob |=> bus_rdata == '0);
    assert_rx_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe && rx_ready && ack_rx |=> !rx_ready);
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_we) |=> $stable(bus_rdata));
endmodule

bind uart_csr_front uart_csr_front_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte),
    .rx_strobe (rx_strobe),
    .rx_byte   (rx_byte),
    .rx_ready  (rx_ready),
    .irq       (irq),
    .rxdata    (chk_rxdata),
    .ctrl      (chk_ctrl)
);

// File: tb/uart_csr_front_tb_top.sv
module uart_csr_front_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_strobe;
    logic [7:0]  tx_byte;
    logic        rx_strobe = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, irq;

    int checks = 0;
    int fails  = 0;

    typedef struct { logic [31:0] exp; string tag; } rd_exp_t;
    rd_exp_t    rd_q[$];
    logic [7:0] tx_q[$];
    logic       rd_issued = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_csr_front dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .rx_strobe(rx_strobe),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a[4:0]; bus_wdata = d;
        if (a[4:2] == 3'd0) tx_q.push_back(d[7:0]);
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [31:0] a, logic [31:0] exp, string tag);
        rd_exp_t e;
        e.exp = exp; e.tag = tag;
        rd_q.push_back(e);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a[4:0];
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic rx_send(logic [7:0] b);
        @(negedge clk);
        rx_strobe = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    // monitor: read results and transmitted bytes
    always @(posedge clk) rd_issued <= bus_valid && !bus_we;

    always @(negedge clk) begin
        if (rd_issued) begin
            if (rd_q.size() == 0) chk("R10 unexpected read data", 32'h1, 32'h0);
            else begin
                rd_exp_t e;
                e = rd_q.pop_front();
                chk(e.tag, bus_rdata, e.exp);
            end
        end
        if (tx_strobe) begin
            if (tx_q.size() == 0) chk("R2 unexpected tx_strobe", 32'h1, 32'h0);
            else chk("R2 tx_byte", {24'h0, tx_byte}, {24'h0, tx_q.pop_front()});
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R10 act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
        bus_read(32'h00, 32'h0, "R1 data");
        bus_read(32'h04, 32'h0, "R1 div");
        bus_read(32'h08, 32'h1, "R1 status");
        bus_read(32'h0C, 32'h0, "R1 ctrl");
        bus_read(32'h10, 32'h0, "R1 dbg");

        // R7 storage widths
        bus_write(32'h04, 32'hFFFF_FFFF);
        bus_read(32'h04, 32'h0000_FFFF, "R7 div");
        bus_write(32'h0C, 32'hFFFF_FFFF);
        bus_read(32'h0C, 32'h7, "R7 ctrl");
        bus_write(32'h0C, 32'h0);
        bus_write(32'h10, 32'hFF);
        bus_read(32'h10, 32'h1, "R7 dbg");

        // R2 transmit, R6 masked
        bus_write(32'h00, 32'h1A5);
        @(negedge clk);
        chk("R2 tx_strobe single", {31'h0, tx_strobe}, 32'h0);
        bus_read(32'h08, 32'h5, "R2 tx event");
        chk("R6 irq masked", {31'h0, irq}, 32'h0);
        bus_write(32'h0C, 32'h2);
        chk("R6 irq tx", {31'h0, irq}, 32'h1);

        // R3 write-one-to-clear
        bus_write(32'h08, 32'hFFFF_FFF9);
        bus_read(32'h08, 32'h5, "R3 zeros keep flags");
        bus_write(32'h08, 32'h4);
        chk("R6 irq after clear", {31'h0, irq}, 32'h0);
        bus_read(32'h08, 32'h1, "R3 cleared");

        // R4 receive
        rx_send(8'h3C);
        chk("R4 rx_ready low", {31'h0, rx_ready}, 32'h0);
        bus_read(32'h00, 32'h3C, "R4 rx data");
        bus_read(32'h08, 32'h3, "R4 rx event");
        chk("R6 irq rx masked", {31'h0, irq}, 32'h0);
        bus_write(32'h0C, 32'h1);
        chk("R6 irq rx", {31'h0, irq}, 32'h1);

        // R5 refused byte
        rx_send(8'h77);
        bus_read(32'h00, 32'h3C, "R5 data kept");
        bus_write(32'h08, 32'h2);
        chk("R3 rx_ready back", {31'h0, rx_ready}, 32'h1);
        chk("R6 irq low", {31'h0, irq}, 32'h0);

        // R9 strobe and acknowledge together
        @(negedge clk);
        rx_strobe = 1'b1; rx_byte = 8'h55;
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h2;
        @(negedge clk);
        rx_strobe = 1'b0; bus_valid = 1'b0; bus_we = 1'b0;
        chk("R9 rx_ready", {31'h0, rx_ready}, 32'h0);
        bus_read(32'h00, 32'h55, "R9 data");

        // R8 out of range
        bus_write(32'h14, 32'hFFFF_FFFF);
        bus_write(32'h18, 32'hFFFF_FFFF);
        bus_write(32'h1C, 32'hFFFF_FFFF);
        bus_read(32'h14, 32'h0, "R8 idx5");
        bus_read(32'h18, 32'h0, "R8 idx6");
        bus_read(32'h1C, 32'h0, "R8 idx7");
        bus_read(32'h04, 32'h0000_FFFF, "R8 div untouched");
        bus_read(32'h0C, 32'h1, "R8 ctrl untouched");

        // R10 hold
        bus_read(32'h04, 32'h0000_FFFF, "R10 read");
        bus_write(32'h10, 32'h0);
        repeat (3) @(negedge clk);
        chk("R10 rdata hold", bus_rdata, 32'h0000_FFFF);

        repeat (2) @(negedge clk);
        chk("R2 tx queue drained", tx_q.size(), 32'h0);
        chk("R10 read queue drained", rd_q.size(), 32'h0);
        finish_run();
    end
endmodule